// File: doc/BRIEF.md
# Register Rename Map with Deferred-Release Free List

This block sits in the dispatch stage of a single-issue out-of-order pipeline. It translates the architectural register numbers of one instruction per cycle into tags of a larger physical register file. A speculative map table holds the current physical tag of every architectural register. A circular free list holds the physical tags that are available. Each dispatched instruction supplies two source register numbers and, optionally, a destination. The block returns the physical tags of both sources. For the destination, it takes a fresh tag from the head of the free list, records it in the map, and reports the tag that the destination held before.

The pipeline keeps that displaced tag with the instruction. When a later instruction that writes the same architectural register commits, the commit port hands the tag back. The tag is then appended to the tail of the free list. A tag is never recycled when it is overwritten at rename, because older in-flight readers may still need it. When no tag is free, an instruction with a destination is held back through a valid/ready handshake. Instructions without a destination always pass.

With the default parameters there are 9 architectural and 16 physical registers. After reset, architectural register i maps to physical tag i. The free list holds tags 9 to 15, smallest at the head.

Top module: `rename_unit`

## Requirements
- R1: After reset, a source read of architectural register i (0 to 8) returns physical tag i.
- R2: After reset the free list holds tags 9, 10, ..., 15 with 9 at the head. Destinations receive tags strictly in list order, one per accepted dispatch with `disp_dst_en`=1.
- R3: Source tags are read from the map as it stands before the same instruction's destination update. A source equal to the destination therefore returns the older tag.
- R4: An accepted dispatch with a destination sets that architectural register's map entry to the newly allocated tag. Later source reads return it.
- R5: `dst_old_phys` reports the tag the destination register was mapped to just before the dispatch.
- R6: A commit with `cmt_valid`=1 and `cmt_free_en`=1 appends `cmt_free_phys` to the tail of the free list. It is allocated only after every tag already in the list.
- R7: With an empty free list, `disp_ready` is 0 for an instruction with a destination. Nothing is allocated and the map is unchanged.
- R8: An instruction with `disp_dst_en`=0 sees `disp_ready`=1 even with an empty free list. It allocates nothing and leaves the map unchanged.
- R9: A release and an allocation in the same cycle both take effect. The list length stays the same.
- R10: A commit with `cmt_valid`=0 or `cmt_free_en`=0 adds nothing to the free list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch slot holds an instruction |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_src0_arch | input | 4 | First source architectural register |
| disp_src1_arch | input | 4 | Second source architectural register |
| disp_dst_en | input | 1 | Instruction writes a destination |
| disp_dst_arch | input | 4 | Destination architectural register |
| src0_phys | output | 4 | Physical tag of first source |
| src1_phys | output | 4 | Physical tag of second source |
| dst_phys | output | 4 | Tag allocated to the destination (free-list head) |
| dst_old_phys | output | 4 | Tag the destination held before this dispatch |
| cmt_valid | input | 1 | A commit happens this cycle |
| cmt_free_en | input | 1 | The committing instruction releases a tag |
| cmt_free_phys | input | 4 | Tag being released |

## Verification
A scripted program of dependent dispatches starts from reset. It covers several patterns: distinct sources and destination, source equal to destination (which separates pre-update from post-update reads), a destination-less instruction between writers, and commits overlapping allocations. The released tags are checked to reappear only after the reset-time tags drain, which separates tail insertion from head insertion. Directed tests then drain the list to empty and check that destination instructions stall while destination-less ones pass. They also check that suppressed commits add nothing, and that a release in the same cycle as an allocation keeps exactly one tag in circulation.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int RN_ARCH_REGS = 9;
  localparam int RN_PHYS_REGS = 16;
endpackage

// File: rtl/rename_map.sv
module rename_map #(
  parameter int ARCH_REGS = rename_pkg::RN_ARCH_REGS,
  parameter int ARCH_W    = 4,
  parameter int TAG_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ARCH_W-1:0] rd0_idx,
  input  logic [ARCH_W-1:0] rd1_idx,
  input  logic [ARCH_W-1:0] rdd_idx,
  output logic [TAG_W-1:0]  rd0_tag,
  output logic [TAG_W-1:0]  rd1_tag,
  output logic [TAG_W-1:0]  rdd_tag,
  input  logic              wr_en,
  input  logic [ARCH_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]  wr_tag
);

  logic [TAG_W-1:0] map_q [ARCH_REGS];
  logic [TAG_W-1:0] map_d [ARCH_REGS];
  logic [ARCH_REGS-1:0] ent_en;

  function automatic logic [TAG_W-1:0] lookup(input logic [ARCH_W-1:0] idx,
                                              input logic [TAG_W-1:0] tbl [ARCH_REGS]);
    logic [TAG_W-1:0] r;
    r = '0;
    for (int i = 0; i < ARCH_REGS; i++) begin
      if (idx == ARCH_W'(i)) r = tbl[i];
    end
    return r;
  endfunction

  always_comb begin
    rd0_tag = lookup(rd0_idx, map_q);
    rd1_tag = lookup(rd1_idx, map_q);
    rdd_tag = lookup(rdd_idx, map_q);
  end

  for (genvar g = 0; g < ARCH_REGS; g++) begin : g_ent
    always_comb begin
      ent_en[g] = wr_en && (wr_idx == ARCH_W'(g));
      map_d[g]  = ent_en[g] ? wr_tag : map_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_q[g] <= TAG_W'(g);
      end else if (ent_en[g]) begin
        map_q[g] <= map_d[g];
      end
    end
  end

  AST_MAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx < ARCH_W'(ARCH_REGS))) |=> (map_q[$past(wr_idx)] == $past(wr_tag))); // R4

endmodule

// File: rtl/rename_freelist.sv
module rename_freelist #(
  parameter int DEPTH = 7,
  parameter int BASE  = 9,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop,
  output logic [TAG_W-1:0] head_tag,
  output logic             empty,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] hd_q, hd_d, tl_q, tl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    hd_d  = pop  ? bump(hd_q) : hd_q;
    tl_d  = push ? bump(tl_q) : tl_q;
    cnt_d = cnt_q;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  assign empty    = (cnt_q == '0);
  assign head_tag = mem_q[hd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q  <= '0;
      tl_q  <= '0;
      cnt_q <= CNT_W'(DEPTH);
    end else begin
      if (pop)          hd_q  <= hd_d;
      if (push)         tl_q  <= tl_d;
      if (push != pop)  cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= TAG_W'(BASE + g);
      end else if (push && (tl_q == PTR_W'(g))) begin
        mem_q[g] <= push_tag;
      end
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (cnt_q != CNT_W'(DEPTH))); // R6
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int ARCH_REGS = rename_pkg::RN_ARCH_REGS,
  parameter int PHYS_REGS = rename_pkg::RN_PHYS_REGS,
  parameter int ARCH_W    = $clog2(ARCH_REGS),
  parameter int TAG_W     = $clog2(PHYS_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic [ARCH_W-1:0] disp_src0_arch,
  input  logic [ARCH_W-1:0] disp_src1_arch,
  input  logic              disp_dst_en,
  input  logic [ARCH_W-1:0] disp_dst_arch,
  output logic [TAG_W-1:0]  src0_phys,
  output logic [TAG_W-1:0]  src1_phys,
  output logic [TAG_W-1:0]  dst_phys,
  output logic [TAG_W-1:0]  dst_old_phys,
  input  logic              cmt_valid,
  input  logic              cmt_free_en,
  input  logic [TAG_W-1:0]  cmt_free_phys
);

  localparam int FREE_DEPTH = PHYS_REGS - ARCH_REGS;

  logic fl_empty, alloc, release_tag;

  assign disp_ready  = !disp_dst_en || !fl_empty;
  assign alloc       = disp_valid && disp_dst_en && !fl_empty;
  assign release_tag = cmt_valid && cmt_free_en;

  rename_map #(
    .ARCH_REGS(ARCH_REGS), .ARCH_W(ARCH_W), .TAG_W(TAG_W)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd0_idx(disp_src0_arch), .rd1_idx(disp_src1_arch), .rdd_idx(disp_dst_arch),
    .rd0_tag(src0_phys), .rd1_tag(src1_phys), .rdd_tag(dst_old_phys),
    .wr_en(alloc), .wr_idx(disp_dst_arch), .wr_tag(dst_phys)
  );

  rename_freelist #(
    .DEPTH(FREE_DEPTH), .BASE(ARCH_REGS), .TAG_W(TAG_W)
  ) u_free (
    .clk(clk), .rst_n(rst_n),
    .pop(alloc), .head_tag(dst_phys), .empty(fl_empty),
    .push(release_tag), .push_tag(cmt_free_phys)
  );

  AST_NEW_DIFFERS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> (dst_phys != dst_old_phys)); // R5
  AST_NODST_NO_MAP_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_dst_en) |=> (src0_phys == $past(src0_phys)) || $past(release_tag)
      || (disp_src0_arch != $past(disp_src0_arch))); // R8

endmodule

// File: tb/tb_rename_unit.sv
`timescale 1ns/1ps
module tb_rename_unit;
  logic clk = 1'b0;
  logic rst_n;
  logic disp_valid, disp_dst_en, cmt_valid, cmt_free_en;
  logic [3:0] s0, s1, dd, ctag;
  logic disp_ready;
  logic [3:0] src0_phys, src1_phys, dst_phys, dst_old_phys;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rename_unit dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_src0_arch(s0), .disp_src1_arch(s1), .disp_dst_en(disp_dst_en),
    .disp_dst_arch(dd), .src0_phys(src0_phys), .src1_phys(src1_phys),
    .dst_phys(dst_phys), .dst_old_phys(dst_old_phys),
    .cmt_valid(cmt_valid), .cmt_free_en(cmt_free_en), .cmt_free_phys(ctag)
  );

  // fields: src0 src1 dst_en dst cmt_en cmt_tag | exp_s0 exp_s1 exp_new exp_old
  localparam logic [39:0] VEC [10] = '{
    40'h1213_00_1293,  // R2 R4 first allocation takes 9
    40'h3313_00_99A9,  // R3 src==dst sees older tag
    40'h3011_00_A0B1,  // R4 map 3 now 10
    40'h1300_00_BA00,  // R8 no destination
    40'h4114_13_4BC4,  // R9 release 3 with allocation
    40'h4410_19_CCD0,  // R9 release 9 with allocation
    40'h0212_00_D2E2,  // R5
    40'h2515_00_E5F5,  // R5
    40'h5616_00_F636,  // R6 released 3 comes after 9..15
    40'h6817_00_3897   // R6 released 9 follows 3
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 0; disp_dst_en = 0; cmt_valid = 0; cmt_free_en = 0;
    s0 = 0; s1 = 0; dd = 0; ctag = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      summary();
    end
  end

  initial begin
    rst_n = 1; idle();
    do_reset();
    // R1 reset map
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); s0 = 4'(i); s1 = 4'(8 - i); #1;
      chk("R1", src0_phys, i);
      chk("R1", src1_phys, 8 - i);
    end
    @(negedge clk); idle(); #1;
    chk("R2", dst_phys, 9);
    chk("R2", disp_ready, 1);

    // table walk
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      s0 = VEC[k][39:36]; s1 = VEC[k][35:32];
      disp_dst_en = VEC[k][28]; dd = VEC[k][27:24];
      cmt_valid = VEC[k][20]; cmt_free_en = VEC[k][20]; ctag = VEC[k][19:16];
      disp_valid = 1; #1;
      chk("R3", src0_phys, int'(VEC[k][15:12]));
      chk("R3", src1_phys, int'(VEC[k][11:8]));
      chk("R8", disp_ready, 1);
      if (VEC[k][28]) begin
        chk("R2", dst_phys, int'(VEC[k][7:4]));
        chk("R5", dst_old_phys, int'(VEC[k][3:0]));
      end
    end
    // map now: 0-13 1-11 2-14 3-10 4-12 5-15 6-3 7-9 8-8, list empty
    @(negedge clk); idle();
    disp_valid = 1; disp_dst_en = 1; dd = 8; #1;
    chk("R7", disp_ready, 0);
    @(negedge clk); disp_dst_en = 0; s0 = 8; s1 = 7; #1;
    chk("R7", src0_phys, 8);
    chk("R8", disp_ready, 1);
    chk("R8", src1_phys, 9);
    // R10 suppressed commits
    @(negedge clk); idle(); cmt_valid = 1; cmt_free_en = 0; ctag = 1;
    @(negedge clk); cmt_valid = 0; cmt_free_en = 1;
    @(negedge clk); idle(); disp_valid = 1; disp_dst_en = 1; dd = 8; #1;
    chk("R10", disp_ready, 0);
    // R9 release 1, then release 10 alongside allocation
    @(negedge clk); idle(); cmt_valid = 1; cmt_free_en = 1; ctag = 1;
    @(negedge clk); idle();
    disp_valid = 1; disp_dst_en = 1; dd = 8; s0 = 8;
    cmt_valid = 1; cmt_free_en = 1; ctag = 10; #1;
    chk("R9", disp_ready, 1);
    chk("R6", dst_phys, 1);
    chk("R5", dst_old_phys, 8);
    chk("R3", src0_phys, 8);
    @(negedge clk); idle(); disp_valid = 1; disp_dst_en = 1; dd = 0; s0 = 8; #1;
    chk("R4", src0_phys, 1);
    chk("R9", dst_phys, 10);
    chk("R5", dst_old_phys, 13);
    chk("R9", disp_ready, 1);
    @(negedge clk); idle(); disp_valid = 1; disp_dst_en = 1; dd = 2; s0 = 0; #1;
    chk("R9", disp_ready, 0);
    chk("R4", src0_phys, 10);
    // reset mid-run restores everything
    do_reset();
    @(negedge clk); s0 = 3; s1 = 8; disp_valid = 1; disp_dst_en = 1; dd = 0; #1;
    chk("R1", src0_phys, 3);
    chk("R1", src1_phys, 8);
    chk("R2", dst_phys, 9);
    chk("R5", dst_old_phys, 0);
    @(negedge clk); idle();
    @(negedge clk);
    summary();
  end
endmodule